// File: doc/BRIEF.md
# Additive Codebook Weight Dequantizer

This block rebuilds compressed neural-network weights. A group of eight consecutive weights is stored as one 8-bit index per codebook. Each codebook is a 256-entry table in which every entry is a vector of eight signed 8-bit values. For each group the block reads one vector from every codebook, adds the vectors lane by lane, and emits the eight reconstructed weights. With two codebooks a group costs 16 index bits, or 2 bits per weight. With three codebooks it costs 3 bits per weight.

The tables are filled through a write port, one whole vector per write, while no lookup is in progress. Groups then stream in at one per cycle under a valid/ready handshake. Each result appears two clock edges after it is accepted. When the consumer holds back, the whole pipeline stalls. The number of codebooks, `NCB`, is a parameter from 1 to 3. Each sum is 2 bits wider than an entry, so three codebooks cannot overflow.

Top module: `cbvq_dequant`

## Requirements
- R1: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Lane j of `out_data` (bits j*10+9..j*10) is the two's-complement sum, over codebooks c, of lane j (bits j*8+7..j*8) of the entry that codebook c holds at the index in `in_idx` bits c*8+7..c*8. The entry is read as it stood when the group was accepted.
- R3: A group accepted on a rising edge (`in_valid` and `in_ready` both 1) shows up on `out_valid`/`out_data` after the next rising edge at which the pipeline advances. A cycle with no accepted group leaves a bubble in the same position.
- R4: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid` and `out_data` hold. Groups come out in order, and none is lost or duplicated.
- R5: While `out_ready` stays 1, `in_ready` stays 1, so one group is accepted and one result is delivered on every cycle.
- R6: A write (`wr_en` 1) is ignored when a group is in the pipeline, or when a group is accepted on the same edge.
- R7: A write whose `wr_book` is not less than `NCB` is ignored.
- R8: Extreme entries give exact results with no wrap: all entries at -128 give -128*NCB, and all at 127 give 127*NCB.
- R9: A write accepted on an idle edge takes effect for any group accepted on a later edge, including the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Request to write one codebook entry |
| wr_book | input | 2 | Codebook selected for the write |
| wr_addr | input | 8 | Entry index to write |
| wr_data | input | 64 | Eight signed 8-bit lanes, lane j at bits j*8+7..j*8 |
| in_valid | input | 1 | An index group is presented |
| in_ready | output | 1 | The block takes the presented group on this edge |
| in_idx | input | NCB*8 | One 8-bit index per codebook, codebook c at bits c*8+7..c*8 |
| out_valid | output | 1 | A reconstructed group is presented |
| out_ready | input | 1 | The consumer takes the presented group |
| out_data | output | 80 | Eight signed 10-bit sums, lane j at bits j*10+9..j*10 |

## Verification
A codebook write and the acceptance of a lookup group can fall on the same edge. The same is true while earlier groups are still in the two pipeline stages or are held by backpressure. The bench provokes both cases: it raises `wr_en` on the cycle that a group enters an empty pipeline, and it holds `wr_en` on an entry while groups stream through and while the output stalls. It then drains the pipeline and reads that entry back through a normal lookup. The reference model applies a write only on an edge where nothing is in flight and nothing is accepted, so a write that leaks through shows up as a data mismatch on the later lookup. A write on an idle edge followed at once by a lookup confirms that the new entry is visible on the very next edge.

// File: rtl/cbvq_dequant.sv
`timescale 1ns/1ps
module cbvq_dequant #(
  parameter int NCB   = 2,
  parameter int LANES = 8,
  parameter int EW    = 8,
  parameter int IDXW  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_book,
  input  logic [IDXW-1:0]           wr_addr,
  input  logic [LANES*EW-1:0]       wr_data,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NCB*IDXW-1:0]       in_idx,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*(EW+2)-1:0]   out_data
);
  localparam int DEPTH = 1 << IDXW;
  localparam int VW    = LANES * EW;
  localparam int SW    = EW + 2;

  logic [VW-1:0]       mem [NCB][DEPTH];
  logic [VW-1:0]       pick_q [NCB];
  logic                s1_v, out_v_q;
  logic [LANES*SW-1:0] sum_d, out_q;
  logic                advance, accept, busy, wr_ok;

  assign advance   = !out_v_q || out_ready;
  assign accept    = in_valid && advance;
  assign busy      = s1_v || out_v_q || accept;
  assign wr_ok     = wr_en && !busy && (int'(wr_book) < NCB);
  assign in_ready  = advance;
  assign out_valid = out_v_q;
  assign out_data  = out_q;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCB; c++)
      if (wr_ok && int'(wr_book) == c) mem[c][wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (accept)
      for (int c = 0; c < NCB; c++) pick_q[c] <= mem[c][in_idx[c*IDXW +: IDXW]];
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      logic signed [SW-1:0] acc;
      acc = '0;
      for (int c = 0; c < NCB; c++)
        acc = acc + SW'($signed(pick_q[c][j*EW +: EW]));
      sum_d[j*SW +: SW] = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      out_v_q <= 1'b0;
    end else if (advance) begin
      s1_v    <= in_valid;
      out_v_q <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && s1_v) out_q <= sum_d;
  end
endmodule

// File: rtl/cbvq_dequant_chk.sv
`timescale 1ns/1ps
module cbvq_dequant_chk #(
  parameter int NCB   = 2,
  parameter int LANES = 8,
  parameter int EW    = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*(EW+2)-1:0] out_data
);
  localparam int SW = EW + 2;
  localparam int LO = -(1 << (EW-1)) * NCB;
  localparam int HI = ((1 << (EW-1)) - 1) * NCB;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready ##1 in_ready |=> out_valid);

  // R3
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready ##1 in_ready |=> !out_valid);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    // R8
    sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'($signed(out_data[j*SW +: SW])) >= LO) &&
                    (int'($signed(out_data[j*SW +: SW])) <= HI));
  end
endmodule

bind cbvq_dequant cbvq_dequant_chk #(.NCB(NCB), .LANES(LANES), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_cbvq_dequant.sv
`timescale 1ns/1ps
module sim_cbvq_dequant;
  localparam int NCB = 2, LANES = 8, EW = 8, SW = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_book = 0;
  logic [7:0] wr_addr = 0;
  logic [63:0] wr_data = 0;
  logic in_valid = 0, out_ready = 1;
  logic [NCB*8-1:0] in_idx = 0;
  logic in_ready, out_valid;
  logic [LANES*SW-1:0] out_data;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  string phase = "R1";

  int cbm [NCB][256][LANES];
  bit m_s1_v = 0, m_out_v = 0;
  logic [LANES*SW-1:0] m_s1_d, m_out_d;

  always #5 clk = ~clk;

  cbvq_dequant #(.NCB(NCB), .LANES(LANES), .EW(EW), .IDXW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_book(wr_book), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  function automatic int pat(int c, int a, int j);
    if (a == 255) return -128;
    if (a == 254) return 127;
    return ((a*37 + j*11 + c*73) % 256) - 128;
  endfunction

  function automatic logic [63:0] pack_vec(int c, int a, int salt);
    logic [63:0] v;
    for (int j = 0; j < LANES; j++) v[j*8 +: 8] = 8'(pat(c, a, j) + salt);
    return v;
  endfunction

  function automatic logic [LANES*SW-1:0] expect_group(logic [NCB*8-1:0] idx);
    logic [LANES*SW-1:0] r;
    for (int j = 0; j < LANES; j++) begin
      int s = 0;
      for (int c = 0; c < NCB; c++) s += cbm[c][idx[c*8 +: 8]][j];
      r[j*SW +: SW] = SW'(s);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1_v = 0; m_out_v = 0;
    end else begin
      bit adv, acc;
      adv = !m_out_v || out_ready;
      acc = in_valid && adv;
      if (wr_en && !(m_s1_v || m_out_v || acc) && int'(wr_book) < NCB)
        for (int j = 0; j < LANES; j++)
          cbm[wr_book][wr_addr][j] = int'($signed(wr_data[j*8 +: 8]));
      if (adv) begin
        m_out_v = m_s1_v; m_out_d = m_s1_d;
        m_s1_v = in_valid;
        if (in_valid) m_s1_d = expect_group(in_idx);
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (!done) begin
      compared++;
      if (out_valid !== m_out_v) begin
        mismatched++;
        $display("FAIL R3 [%s] out_valid=%0b expected %0b at cycle %0d", phase, out_valid, m_out_v, cyc);
      end
      compared++;
      if (in_ready !== (!m_out_v || out_ready)) begin
        mismatched++;
        $display("FAIL R4/R5 [%s] in_ready=%0b expected %0b at cycle %0d", phase, in_ready, !m_out_v || out_ready, cyc);
      end
      if (m_out_v) begin
        compared++;
        if (out_data !== m_out_d) begin
          mismatched++;
          $display("FAIL R2 [%s] out_data=%h expected %h at cycle %0d", phase, out_data, m_out_d, cyc);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(bit v, logic [NCB*8-1:0] idx, bit ordy);
    in_valid = v; in_idx = idx; out_ready = ordy;
    @(negedge clk);
  endtask

  task automatic wr(int b, int a, logic [63:0] d);
    wr_en = 1; wr_book = 2'(b); wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drain();
    in_valid = 0; out_ready = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCB; c++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < LANES; j++) cbm[c][a][j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    phase = "R9_load";
    for (int c = 0; c < NCB; c++)
      for (int a = 0; a < 256; a++) wr(c, a, pack_vec(c, a, 0));

    phase = "R7";
    wr(NCB, 5, 64'h0);
    wr(3, 6, 64'h0101010101010101);
    step(1, {8'd6, 8'd5}, 1);
    drain();

    phase = "R5";
    for (int k = 0; k < 40; k++) step(1, NCB*8'($urandom), 1);
    drain();

    phase = "R8";
    step(1, {8'd255, 8'd255}, 1);
    step(1, {8'd254, 8'd254}, 1);
    step(1, {8'd254, 8'd255}, 1);
    drain();

    phase = "R4";
    for (int k = 0; k < 300; k++)
      step(($urandom % 10) < 7, NCB*8'($urandom), ($urandom % 2) == 1);
    drain();

    phase = "R6";
    wr_en = 1; wr_book = 0; wr_addr = 10; wr_data = 64'h7F7F7F7F7F7F7F7F;
    step(1, {8'd1, 8'd2}, 1);
    step(1, {8'd3, 8'd4}, 1);
    step(1, {8'd5, 8'd6}, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    wr_en = 0;
    drain();
    step(1, {8'd0, 8'd10}, 1);
    drain();

    phase = "R9";
    wr(1, 20, pack_vec(1, 20, 3));
    step(1, {8'd20, 8'd3}, 1);
    drain();
    wr(0, 10, pack_vec(0, 10, 9));
    step(1, {8'd20, 8'd10}, 1);
    step(1, {8'd255, 8'd10}, 1);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule